// File: doc/BRIEF.md
# I2C Bus Target with Clock Stretching

This block is the target side of a two-wire serial bus. It oversamples the clock and data lines with the system clock, finds start and stop conditions, and compares the first byte after a start against a fixed 7-bit address. On a match it acknowledges. It then either collects bytes written by the controller and hands each one to local logic, or fetches bytes from local logic and shifts them out to the controller. Both bus lines are open-drain. The block only ever asks for a line to be pulled low, and the pad or the board resistor supplies the high level.

On the local side, a received byte appears with a one-cycle strobe. The byte is accepted only while the local side reports that it has room. When it has no room, the byte is refused on the bus with a not-acknowledge. For reads, the block raises a request and waits for local logic to present a byte with a ready flag. While it waits, it holds the clock line low so the controller cannot start the next bit.

A repeated start sends the block back to address matching. A stop returns it to idle from any state. After an address mismatch, a refused write byte or a not-acknowledged read byte, the block stays off the bus until the next start or stop.

Top module: `i2c_target`

## Requirements
- R1: While reset is asserted and right after it, both line pull-downs are off, and `rx_valid` and `tx_req` are low.
- R2: A stop (data rising while clock is high) returns the block to idle from any state, including mid-byte, and releases both lines. Bus activity after a stop and before the next start draws no acknowledge.
- R3: The first byte after a start is taken MSB first. Bits 7..1 are the address and bit 0 is the direction (1 = read, 0 = write). The block pulls data low in the acknowledge slot only when bits 7..1 equal `OWN_ADDR`. On a mismatch, nothing is driven until the next start or stop.
- R4: In a write, each data byte is assembled MSB first. If `rx_space` is high when the eighth clock falls, the byte appears on `rx_data` with `rx_valid` high for exactly one cycle, and an acknowledge (data low) is driven.
- R5: If `rx_space` is low at that point, no `rx_valid` is produced, data is left released (not-acknowledge), and later bytes of the same transfer are ignored.
- R6: In a read, `tx_req` rises once the acknowledge slot ends. A byte is consumed in a cycle where `tx_req` and `tx_ready` are both high, and it is shifted out MSB first. `tx_req` stays high until consumed or until a start or stop.
- R7: While `tx_req` is high and no byte has been consumed, the clock line is held low, so the controller's next clock high phase is delayed until data is available.
- R8: After a read byte, a controller acknowledge (data low) leads to another fetch. A not-acknowledge releases data, and no further `tx_req` occurs until the next start.
- R9: The data pull-down changes only while the synchronised clock line is low.
- R10: A repeated start in any state (including after a mismatch) restarts address matching, and a matching address is acknowledged again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled level of the bus clock line |
| sda_in | input | 1 | Sampled level of the bus data line |
| scl_drive_low | output | 1 | 1 pulls the clock line low (stretch) |
| sda_drive_low | output | 1 | 1 pulls the data line low |
| rx_data | output | 8 | Last byte written by the controller |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a new byte |
| rx_space | input | 1 | Local side can accept a byte |
| tx_data | input | 8 | Byte to send to the controller |
| tx_ready | input | 1 | `tx_data` is valid |
| tx_req | output | 1 | Block needs the next read byte |

## Verification
The hardest situation to reach is a read where local data arrives late. The controller has to find its clock held low, wait it out, and still sample a correct MSB after the release. The bench models both lines as wired-AND of controller and target. Its controller waits for the clock line to actually go high, and the byte supplier answers `tx_req` only after a programmed delay, so every fetch stretches the clock and the stretch length is measured. Refused writes and mismatched addresses are checked at the ports by confirming that no acknowledge and no receive strobe follow.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W) + 1;
    localparam logic [CNT_W-1:0] BYTE_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_FETCH,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_RD_NEXT,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e        state;
        logic [CNT_W-1:0]  bits;
        logic [BYTE_W-1:0] shreg;
        logic              rnw;
        logic              ack_ok;
        logic              sda_low;
        logic              scl_low;
        logic              rx_valid;
        logic [BYTE_W-1:0] rx_data;
    } tgt_regs_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign dout[i] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_p_d, scl_p_q;
    logic sda_p_d, sda_p_q;

    always_comb begin
        scl_p_d  = scl_s;
        sda_p_d  = sda_s;
        scl_rise = !scl_p_q && scl_s;
        scl_fall = scl_p_q && !scl_s;
        start_ev = scl_p_q && scl_s && sda_p_q && !sda_s;
        stop_ev  = scl_p_q && scl_s && !sda_p_q && sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_p_d;
            sda_p_q <= sda_p_d;
        end
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'h42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              rx_space,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              sda_low,
    output logic              scl_low,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              tx_req
);
    tgt_regs_t d, q;

    always_comb begin
        d          = q;
        d.rx_valid = 1'b0;
        if (stop_ev) begin
            d.state   = ST_IDLE;
            d.sda_low = 1'b0;
            d.bits    = '0;
        end else if (start_ev) begin
            d.state   = ST_ADDR;
            d.sda_low = 1'b0;
            d.bits    = '0;
        end else begin
            case (q.state)
                ST_ADDR: begin
                    if (scl_rise && q.bits != BYTE_CNT) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                        d.bits  = q.bits + 1'b1;
                    end else if (scl_fall && q.bits == BYTE_CNT) begin
                        if (q.shreg[BYTE_W-1:1] == OWN_ADDR) begin
                            d.sda_low = 1'b1;
                            d.rnw     = q.shreg[0];
                            d.state   = ST_ADDR_ACK;
                        end else begin
                            d.state = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.sda_low = 1'b0;
                        d.bits    = '0;
                        d.state   = q.rnw ? ST_RD_FETCH : ST_WR_DATA;
                    end
                end
                ST_WR_DATA: begin
                    if (scl_rise && q.bits != BYTE_CNT) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                        d.bits  = q.bits + 1'b1;
                    end else if (scl_fall && q.bits == BYTE_CNT) begin
                        d.state = ST_WR_ACK;
                        if (rx_space) begin
                            d.rx_valid = 1'b1;
                            d.rx_data  = q.shreg;
                            d.sda_low  = 1'b1;
                            d.ack_ok   = 1'b1;
                        end else begin
                            d.ack_ok = 1'b0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.sda_low = 1'b0;
                        d.bits    = '0;
                        d.state   = q.ack_ok ? ST_WR_DATA : ST_IGNORE;
                    end
                end
                ST_RD_FETCH: begin
                    if (tx_ready) begin
                        d.shreg   = tx_data;
                        d.sda_low = !tx_data[BYTE_W-1];
                        d.bits    = '0;
                        d.state   = ST_RD_DATA;
                    end
                end
                ST_RD_DATA: begin
                    if (scl_fall) begin
                        if (q.bits == LAST_TX) begin
                            d.sda_low = 1'b0;
                            d.bits    = '0;
                            d.state   = ST_RD_ACK;
                        end else begin
                            d.shreg   = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.sda_low = !q.shreg[BYTE_W-2];
                            d.bits    = q.bits + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) d.state = sda_s ? ST_IGNORE : ST_RD_NEXT;
                end
                ST_RD_NEXT: begin
                    if (scl_fall) d.state = ST_RD_FETCH;
                end
                default: ;
            endcase
        end
        // Stretch through the fetch and one cycle past the load, so the
        // first data bit settles before the clock line is let go.
        d.scl_low = (d.state == ST_RD_FETCH) ||
                    (q.state == ST_RD_FETCH && d.state == ST_RD_DATA);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_low  = q.sda_low;
    assign scl_low  = q.scl_low;
    assign rx_data  = q.rx_data;
    assign rx_valid = q.rx_valid;
    assign tx_req   = (q.state == ST_RD_FETCH);
endmodule

// File: rtl/i2c_target.sv
module i2c_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR    = 7'h42,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_space,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              tx_req
);
    logic [1:0] line_sync;
    logic       scl_sync, sda_sync;
    logic       scl_rise, scl_fall, start_ev, stop_ev;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_in, sda_in}),
        .dout  (line_sync)
    );

    assign scl_sync = line_sync[1];
    assign sda_sync = line_sync[0];

    i2c_tgt_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_sync),
        .sda_s    (sda_sync),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_tgt_engine #(.OWN_ADDR(OWN_ADDR)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_sync),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rx_space (rx_space),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .sda_low  (sda_drive_low),
        .scl_low  (scl_drive_low),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .tx_req   (tx_req)
    );
endmodule

// File: rtl/i2c_target_chk.sv
module i2c_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_sync,
    input logic start_ev,
    input logic stop_ev,
    input logic sda_drive_low,
    input logic scl_drive_low,
    input logic tx_req,
    input logic tx_ready,
    input logic rx_valid,
    input logic rx_space
);
    p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!sda_drive_low && !scl_drive_low && !tx_req));

    p_rx_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_rx_needs_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rx_space));

    p_req_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_ready && !start_ev && !stop_ev) |=> tx_req);

    p_stretch_when_waiting_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_low |-> (tx_req || $past(tx_req)));

    p_sda_moves_low_scl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low)) |-> !$past(scl_sync));
endmodule

bind i2c_target i2c_target_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_sync      (scl_sync),
    .start_ev      (start_ev),
    .stop_ev       (stop_ev),
    .sda_drive_low (sda_drive_low),
    .scl_drive_low (scl_drive_low),
    .tx_req        (tx_req),
    .tx_ready      (tx_ready),
    .rx_valid      (rx_valid),
    .rx_space      (rx_space)
);

// File: tb/tb_i2c_target.sv
`timescale 1ns/1ps
module tb_i2c_target;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_line, sda_line;
    logic scl_drive_low, sda_drive_low;
    logic [7:0] rx_data;
    logic rx_valid, tx_req;
    logic rx_space = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic tx_ready = 1'b0;

    int vectors = 0, miscompares = 0;
    logic [7:0] rx_exp[$];
    logic [7:0] tx_q[$];
    logic [7:0] rd_exp[$];
    int tx_delay = 0, wait_cnt = 0, tx_pops = 0;
    int run_len = 0, run_max = 0;
    int r9_viol = 0;
    logic prev_sda_drv = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_line = m_scl & ~scl_drive_low;
    assign sda_line = m_sda & ~sda_drive_low;

    i2c_target dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_space(rx_space),
        .tx_data(tx_data), .tx_ready(tx_ready), .tx_req(tx_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor for received bytes (R4) and stray strobes (R5)
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (rx_exp.size() == 0) chk("R5 unexpected receive strobe", 1, 0);
            else chk("R4 received byte", {24'h0, rx_data}, {24'h0, rx_exp.pop_front()});
        end
    end

    // Read-byte supplier with programmable latency, plus stretch and R9 monitors
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_ready && !tx_req) begin
                tx_ready <= 1'b0;
                void'(tx_q.pop_front());
                tx_pops++;
            end else if (!tx_ready && tx_req) begin
                if (wait_cnt >= tx_delay && tx_q.size() != 0) begin
                    tx_data  <= tx_q[0];
                    tx_ready <= 1'b1;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
            if (scl_drive_low) begin
                run_len++;
                if (run_len > run_max) run_max = run_len;
            end else begin
                run_len = 0;
            end
            if (sda_drive_low != prev_sda_drv && scl_line) r9_viol++;
            prev_sda_drv = sda_drive_low;
        end
    end

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_high();
        m_scl = 1'b1;
        for (int i = 0; i < 5000 && !scl_line; i++) @(negedge clk);
    endtask

    task automatic send_start();
        m_sda = 1'b1; wait_q(Q);
        scl_high();   wait_q(Q);
        m_sda = 1'b0; wait_q(Q);
        m_scl = 1'b0; wait_q(Q);
    endtask

    task automatic send_stop();
        m_sda = 1'b0; wait_q(Q);
        scl_high();   wait_q(Q);
        m_sda = 1'b1; wait_q(2*Q);
    endtask

    task automatic write_bit(input logic b);
        m_sda = b; wait_q(Q);
        scl_high(); wait_q(2*Q);
        m_scl = 1'b0; wait_q(Q);
    endtask

    task automatic read_bit(output logic b);
        m_sda = 1'b1; wait_q(Q);
        scl_high(); wait_q(Q);
        b = sda_line; wait_q(Q);
        m_scl = 1'b0; wait_q(Q);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) write_bit(v[i]);
        read_bit(b);
        acked = !b;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        v = 8'h00;
        for (int i = 0; i < 8; i++) begin
            read_bit(b);
            v = {v[6:0], b};
        end
        write_bit(!give_ack);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("R2 watchdog expired", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] rd;
        int pops0;

        // R1: reset state
        repeat (10) @(negedge clk);
        chk("R1 scl pull-down in reset", scl_drive_low, 0);
        chk("R1 sda pull-down in reset", sda_drive_low, 0);
        chk("R1 strobes in reset", {rx_valid, tx_req}, 0);
        rst_n = 1'b1;
        wait_q(4);
        chk("R1 outputs after reset", {scl_drive_low, sda_drive_low, rx_valid, tx_req}, 0);

        // Write of two bytes
        send_start();
        write_byte(8'h84, ack); chk("R3 own address write ack", ack, 1);
        rx_exp.push_back(8'hA5);
        write_byte(8'hA5, ack); chk("R4 first byte ack", ack, 1);
        rx_exp.push_back(8'h3C);
        write_byte(8'h3C, ack); chk("R4 second byte ack", ack, 1);
        send_stop();
        wait_q(Q);
        chk("R2 lines released after stop", {scl_drive_low, sda_drive_low}, 0);

        // Mismatched address
        send_start();
        write_byte(8'h2E, ack); chk("R3 foreign address no ack", ack, 0);
        write_byte(8'h99, ack); chk("R3 data after mismatch no ack", ack, 0);
        send_stop();

        // No space for a write byte
        send_start();
        write_byte(8'h84, ack); chk("R3 address ack", ack, 1);
        rx_exp.push_back(8'h5A);
        write_byte(8'h5A, ack); chk("R4 byte with space ack", ack, 1);
        rx_space = 1'b0;
        write_byte(8'hC3, ack); chk("R5 byte without space nack", ack, 0);
        rx_space = 1'b1;
        write_byte(8'h77, ack); chk("R5 byte after refusal ignored", ack, 0);
        send_stop();

        // Stop in the middle of a byte, then traffic without a start
        send_start();
        write_byte(8'h84, ack); chk("R3 address ack before abort", ack, 1);
        write_bit(1'b1); write_bit(1'b0); write_bit(1'b1); write_bit(1'b1);
        send_stop();
        chk("R2 released after mid-byte stop", {scl_drive_low, sda_drive_low}, 0);
        m_scl = 1'b0; wait_q(Q);
        write_byte(8'h84, ack); chk("R2 no ack without start", ack, 0);
        send_stop();

        // Read of three bytes with late local data (clock stretching)
        tx_delay = 20;
        run_max  = 0;
        pops0    = tx_pops;
        tx_q.push_back(8'h81); rd_exp.push_back(8'h81);
        tx_q.push_back(8'h5E); rd_exp.push_back(8'h5E);
        tx_q.push_back(8'hF0); rd_exp.push_back(8'hF0);
        send_start();
        write_byte(8'h85, ack); chk("R3 own address read ack", ack, 1);
        read_byte(1'b1, rd); chk("R6 first read byte", rd, rd_exp.pop_front());
        read_byte(1'b1, rd); chk("R8 byte after controller ack", rd, rd_exp.pop_front());
        read_byte(1'b0, rd); chk("R6 last read byte", rd, rd_exp.pop_front());
        chk("R7 clock held at least the supplier delay", run_max >= 20, 1);
        read_byte(1'b0, rd); chk("R8 bus released after nack", rd, 8'hFF);
        chk("R8 no fetch after nack", tx_pops - pops0, 3);
        chk("R8 no request after nack", tx_req, 0);
        send_stop();

        // Repeated starts
        send_start();
        write_byte(8'h84, ack); chk("R10 address ack", ack, 1);
        rx_exp.push_back(8'h11);
        write_byte(8'h11, ack); chk("R4 byte before repeated start", ack, 1);
        send_start();
        write_byte(8'h84, ack); chk("R10 ack after repeated start", ack, 1);
        rx_exp.push_back(8'h22);
        write_byte(8'h22, ack); chk("R10 byte after repeated start", ack, 1);
        send_start();
        write_byte(8'h2E, ack); chk("R3 mismatch on repeated start", ack, 0);
        send_start();
        write_byte(8'h84, ack); chk("R10 ack after mismatch", ack, 1);
        rx_exp.push_back(8'h33);
        write_byte(8'h33, ack); chk("R10 byte after mismatch recovery", ack, 1);
        send_stop();
        wait_q(4*Q);

        chk("R4 all expected bytes delivered", rx_exp.size(), 0);
        chk("R9 data moved while clock high", r9_viol, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule